// File: doc/BRIEF.md
# Barrel Shifter Operand Unit

This block produces the second ALU operand and the shifter carry for a data-processing instruction in a 32-bit integer datapath. It is purely combinational. Decode supplies an operand-form select, a shift kind, the immediate fields, the source register value, the shift-amount register value and the current carry flag. The unit returns the shaped operand and a carry that the ALU uses when the instruction updates flags through a logical operation.

There are three operand forms. The first is an 8-bit constant rotated right by an even amount. The second is a register shifted by a 5-bit immediate amount. The third is a register shifted by an amount taken from the low byte of a second register. The immediate-amount form follows the usual special encodings for a zero amount: a right shift by zero stands for a shift by 32, and a rotate by zero stands for a one-bit rotate through the carry. The register-amount form saturates or wraps for amounts of 32 and above, depending on the shift kind.

Top module: `barrel_operand_unit`

## Requirements
- R1: With `form_sel` = 0 (rotated immediate), `operand` equals `imm_byte` zero-extended to 32 bits and rotated right by twice `imm_rot` (0, 2, ... 30).
- R2: In the rotated-immediate form, `carry_out` equals bit 31 of `operand` when `imm_rot` is nonzero, and equals `carry_in` when `imm_rot` is zero.
- R3: With `form_sel` = 1 (immediate amount) and `imm_amt` from 1 to 31, `shift_kind` 0 = LSL and 1 = LSR fill vacated bits with zeros, 2 = ASR fills with bit 31 of `src_val`, and 3 = ROR rotates right.
- R4: For any shift by an amount from 1 to 31, `carry_out` is the last bit shifted out of `src_val`.
- R5: In the immediate-amount form with `imm_amt` = 0, LSL passes `src_val` through with `carry_out` = `carry_in`, while LSR and ASR act as a shift by 32.
- R6: In the immediate-amount form, ROR with `imm_amt` = 0 is a 33-bit rotate right by one: `carry_in` enters bit 31, and bit 0 of `src_val` leaves as `carry_out`.
- R7: With `form_sel` = 2 or 3 (register amount), only bits 7:0 of `amt_reg` set the amount. An amount of 0 passes `src_val` through with `carry_out` = `carry_in`.
- R8: In the register-amount form, LSL or LSR by exactly 32 gives 0 with carry equal to bit 0 or bit 31 of `src_val` respectively. Amounts above 32 give 0 with carry 0.
- R9: In the register-amount form, ASR by 32 or more gives 32 copies of bit 31 of `src_val`, and `carry_out` equals that bit.
- R10: In the register-amount form, ROR uses the amount modulo 32. A nonzero multiple of 32 returns `src_val` unchanged with `carry_out` equal to its bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| form_sel | input | 2 | 0 rotated immediate, 1 immediate amount, 2 or 3 register amount |
| shift_kind | input | 2 | 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| imm_byte | input | 8 | Constant for the rotated-immediate form |
| imm_rot | input | 4 | Half the right-rotate amount for the constant |
| imm_amt | input | 5 | Shift amount in the immediate-amount form |
| src_val | input | 32 | Register value to be shifted |
| amt_reg | input | 32 | Register whose low byte holds the shift amount |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Shaped second operand |
| carry_out | output | 1 | Shifter carry |

## Verification
The cases that are hardest to reach are those where the register amount reaches or passes the word width. This happens only when the amount register carries values of 32 and above, and when its upper bytes are nonzero but must be ignored. The bench sweeps every shift kind over amounts 0 through 40. It adds the boundary values 63, 64, 96, 200 and 255, and amount words whose upper bits are set while the low byte is small. Each result is compared with a bit-by-bit stepping model that also produces the last bit shifted out.

// File: rtl/barrel_operand_unit.sv
module barrel_operand_unit #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [1:0]                 form_sel,
  input  logic [1:0]                 shift_kind,
  input  logic [7:0]                 imm_byte,
  input  logic [3:0]                 imm_rot,
  input  logic [$clog2(DATA_W)-1:0]  imm_amt,
  input  logic [DATA_W-1:0]          src_val,
  input  logic [DATA_W-1:0]          amt_reg,
  input  logic                       carry_in,
  output logic [DATA_W-1:0]          operand,
  output logic                       carry_out
);

  localparam int SH_W = $clog2(DATA_W);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);
  localparam logic [1:0] FORM_ROT = 2'd0;
  localparam logic [1:0] FORM_IMM = 2'd1;
  localparam logic [1:0] K_LSL = 2'd0;
  localparam logic [1:0] K_LSR = 2'd1;
  localparam logic [1:0] K_ASR = 2'd2;

  wire [DATA_W-1:0]   imm_ext = DATA_W'(imm_byte);
  wire [2*DATA_W-1:0] imm_dbl = {imm_ext, imm_ext} >> {imm_rot, 1'b0};
  wire [DATA_W-1:0]   rot_val = imm_dbl[DATA_W-1:0];

  logic [AMT_W-1:0] amt;
  logic             use_rrx;

  always_comb begin
    use_rrx = 1'b0;
    if (form_sel == FORM_IMM) begin
      if (imm_amt == '0) begin
        amt     = (shift_kind == K_LSL) ? '0 : FULL;
        use_rrx = (shift_kind == 2'd3);
      end else begin
        amt = AMT_W'(imm_amt);
      end
    end else begin
      amt = amt_reg[AMT_W-1:0];
    end
  end

  wire [AMT_W-1:0]    amt_sat = (amt > FULL) ? FULL : amt;
  wire [DATA_W:0]     lsl_ext = {1'b0, src_val} << amt;
  wire [DATA_W:0]     lsr_ext = {src_val, 1'b0} >> amt;
  wire [DATA_W:0]     asr_ext = $signed({src_val, 1'b0}) >>> amt_sat;
  wire [2*DATA_W-1:0] ror_dbl = {src_val, src_val} >> amt[SH_W-1:0];

  always_comb begin
    if (form_sel == FORM_ROT) begin
      operand   = rot_val;
      carry_out = (imm_rot != '0) ? rot_val[DATA_W-1] : carry_in;
    end else if (use_rrx) begin
      operand   = {carry_in, src_val[DATA_W-1:1]};
      carry_out = src_val[0];
    end else if (amt == '0) begin
      operand   = src_val;
      carry_out = carry_in;
    end else begin
      case (shift_kind)
        K_LSL: begin
          operand   = lsl_ext[DATA_W-1:0];
          carry_out = lsl_ext[DATA_W];
        end
        K_LSR: begin
          operand   = lsr_ext[DATA_W:1];
          carry_out = lsr_ext[0];
        end
        K_ASR: begin
          operand   = asr_ext[DATA_W:1];
          carry_out = asr_ext[0];
        end
        default: begin
          operand   = ror_dbl[DATA_W-1:0];
          carry_out = ror_dbl[DATA_W-1];
        end
      endcase
    end
  end

endmodule

// File: rtl/barrel_operand_checks.sv
module barrel_operand_checks #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input logic [1:0]                 form_sel,
  input logic [1:0]                 shift_kind,
  input logic [7:0]                 imm_byte,
  input logic [3:0]                 imm_rot,
  input logic [$clog2(DATA_W)-1:0]  imm_amt,
  input logic [DATA_W-1:0]          src_val,
  input logic [DATA_W-1:0]          amt_reg,
  input logic                       carry_in,
  input logic [DATA_W-1:0]          operand,
  input logic                       carry_out
);
  wire reg_form = form_sel[1];
  wire [AMT_W-1:0] ramt = amt_reg[AMT_W-1:0];

  always_comb begin
    if (form_sel == 2'd0 && imm_rot == 4'd0)
      assert_rot_zero_R1: assert (operand == DATA_W'(imm_byte) && carry_out == carry_in);
    if (form_sel == 2'd0 && imm_rot != 4'd0)
      assert_rot_carry_R2: assert (carry_out == operand[DATA_W-1]);
    if (form_sel == 2'd1 && imm_amt == '0 && shift_kind == 2'd3)
      assert_rrx_R6: assert (carry_out == src_val[0] && operand[DATA_W-1] == carry_in);
    if (reg_form && ramt == '0)
      assert_reg_zero_R7: assert (operand == src_val && carry_out == carry_in);
    if (reg_form && shift_kind == 2'd0 && ramt > AMT_W'(DATA_W))
      assert_lsl_over_R8: assert (operand == '0 && carry_out == 1'b0);
    if (reg_form && shift_kind == 2'd2 && ramt >= AMT_W'(DATA_W))
      assert_asr_sat_R9: assert (operand == {DATA_W{src_val[DATA_W-1]}} && carry_out == src_val[DATA_W-1]);
    if (reg_form && shift_kind == 2'd3 && ramt != '0 && ramt[$clog2(DATA_W)-1:0] == '0)
      assert_ror_wrap_R10: assert (operand == src_val && carry_out == src_val[DATA_W-1]);
  end
endmodule

bind barrel_operand_unit barrel_operand_checks #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_checks (
  .form_sel(form_sel), .shift_kind(shift_kind), .imm_byte(imm_byte), .imm_rot(imm_rot),
  .imm_amt(imm_amt), .src_val(src_val), .amt_reg(amt_reg), .carry_in(carry_in),
  .operand(operand), .carry_out(carry_out)
);

// File: tb/barrel_operand_unit_test.sv
module barrel_operand_unit_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic [1:0]  form_sel = '0;
  logic [1:0]  shift_kind = '0;
  logic [7:0]  imm_byte = '0;
  logic [3:0]  imm_rot = '0;
  logic [4:0]  imm_amt = '0;
  logic [31:0] src_val = '0;
  logic [31:0] amt_reg = '0;
  logic        carry_in = 1'b0;
  logic [31:0] operand;
  logic        carry_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  barrel_operand_unit uut (
    .form_sel(form_sel), .shift_kind(shift_kind), .imm_byte(imm_byte), .imm_rot(imm_rot),
    .imm_amt(imm_amt), .src_val(src_val), .amt_reg(amt_reg), .carry_in(carry_in),
    .operand(operand), .carry_out(carry_out)
  );

  function automatic logic [32:0] step_model(input logic [1:0] k, input logic [31:0] x,
                                             input int n, input logic c);
    logic [31:0] r = x;
    logic co = c;
    for (int i = 0; i < n; i++) begin
      case (k)
        2'd0: begin co = r[31]; r = {r[30:0], 1'b0}; end
        2'd1: begin co = r[0];  r = {1'b0, r[31:1]}; end
        2'd2: begin co = r[0];  r = {r[31], r[31:1]}; end
        default: begin co = r[0]; r = {r[0], r[31:1]}; end
      endcase
    end
    return {co, r};
  endfunction

  task automatic check(input string tag, input logic [32:0] exp);
    #(PERIOD/4);
    checks++;
    if ({carry_out, operand} !== exp) begin
      fails++;
      $display("FAIL %s form=%0d kind=%0d src=%h amt=%h imm=%h/%0d/%0d cin=%0b: got c=%0b op=%h exp c=%0b op=%h",
               tag, form_sel, shift_kind, src_val, amt_reg, imm_byte, imm_rot, imm_amt, carry_in,
               carry_out, operand, exp[32], exp[31:0]);
    end
  endtask

  logic [31:0] pats [4] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_0F96, 32'h0000_0000};
  int          ramts [9] = '{63, 64, 96, 200, 255, 32'h0000_0105, 32'h1234_0120, 32'hFFFF_FF00, 32'h8000_0040};

  initial begin
    @(negedge clk);
    check("R1", 33'h0);

    // R1, R2: every constant and rotation
    form_sel = 2'd0;
    for (int b = 0; b < 256; b++)
      for (int r = 0; r < 16; r++) begin
        @(negedge clk);
        imm_byte = 8'(b); imm_rot = 4'(r); carry_in = b[0] ^ r[0];
        check(r == 0 ? "R1" : "R2", step_model(2'd3, {24'h0, 8'(b)}, 2*r, carry_in));
      end

    // R3..R6: immediate amounts
    form_sel = 2'd1;
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 32; a++)
        for (int p = 0; p < 4; p++)
          for (int c = 0; c < 2; c++) begin
            logic [32:0] e;
            string tag;
            @(negedge clk);
            shift_kind = 2'(k); imm_amt = 5'(a); src_val = pats[p]; carry_in = c[0];
            if (a != 0) begin
              e = step_model(2'(k), pats[p], a, c[0]);
              tag = (p == 2) ? "R4" : "R3";
            end else if (k == 3) begin
              e = {pats[p][0], c[0], pats[p][31:1]};
              tag = "R6";
            end else begin
              e = step_model(2'(k), pats[p], (k == 0) ? 0 : 32, c[0]);
              tag = "R5";
            end
            check(tag, e);
          end

    // R7..R10: register amounts
    form_sel = 2'd2;
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 50; a++)
        for (int p = 0; p < 4; p++)
          for (int c = 0; c < 2; c++) begin
            int n;
            string tag;
            @(negedge clk);
            amt_reg = (a < 41) ? 32'(a) : 32'(ramts[a-41]);
            form_sel = (a % 2 == 0) ? 2'd2 : 2'd3;
            shift_kind = 2'(k); src_val = pats[p]; carry_in = c[0];
            n = int'(amt_reg[7:0]);
            if (n == 0 || a >= 46) tag = "R7";
            else if (n < 32) tag = "R4";
            else if (k < 2) tag = "R8";
            else if (k == 2) tag = "R9";
            else tag = "R10";
            check(tag, step_model(2'(k), pats[p], n, c[0]));
          end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule